// File: doc/BRIEF.md
# HDLC Bit-Serial Frame Transmitter

This block turns a stream of packet bytes into an HDLC bitstream, one line bit for each pulse of a bit-rate enable. It reads bytes from a show-ahead byte queue. Each byte arrives with a start-of-packet mark and an end-of-packet mark. The block frames each packet with 7Eh flags and inserts a zero after every run of five ones inside the frame body. It can append a 16-bit frame check sequence. Between frames it keeps the line busy with a configurable fill.

Run-time controls cover six choices: dropping the check sequence, corrupting it on purpose, the fill pattern, which end of each data byte goes out first, inverting the line, and a graceful hold. The hold lets the packet in flight finish and then starts no new packet. If the queue runs dry in the middle of a packet, the frame is aborted.

Top module: `hdlc_tx_engine`

## Requirements
- R1: While reset is asserted and after its release, the pre-inversion line level is 1 and `fifo_pop` stays low until a byte is needed. The engine begins in fill.
- R2: Between frames the engine sends 8-bit fill units. With `cfg_fill_ones`=0 each unit is 7Eh, bit 0 first (0,1,1,1,1,1,1,0). With `cfg_fill_ones`=1 every fill bit is 1. The level is read for each bit as it is sent.
- R3: A frame starts at the next unit boundary when the queue head carries the start mark and no hold is requested. The frame is a 7Eh opening flag, the data bytes, and then a closing flag. Each byte is popped in the bit-enable cycle that sends the last bit of the previous unit. `fifo_pop` is only ever high together with `bit_en` and a non-empty queue.
- R4: With `cfg_msb_first`=0, bit 0 of each data byte is sent first. With `cfg_msb_first`=1, bit 7 is sent first.
- R5: After five consecutive 1s among data and check bits, one 0 is inserted. Flags, fill and abort bits get no insertion and reset the run count.
- R6: When `cfg_fcs_off`=0, the data bytes are followed by the ones' complement of a CRC-16, sent bit 0 first. The CRC is reflected polynomial 8408h, seeded with FFFFh, and runs over the data bits in line order. The closing flag follows the check sequence, and at least one fill unit follows the closing flag.
- R7: With `cfg_fcs_corrupt`=1 the uncomplemented CRC is sent instead. This control has no effect when `cfg_fcs_off`=1.
- R8: With `cfg_fcs_off`=1 the closing flag follows the last data byte directly.
- R9: With `cfg_invert`=1, `ser_out` is the complement of the line bit after all other processing, including the idle level.
- R10: While `cfg_hold_start`=1 no new frame is started and the held head byte is not popped. Clearing the control lets the frame start.
- R11: If the queue is empty when the next byte of an unfinished packet is needed, the engine sends eight 1s and then returns to fill.
- R12: During fill, a head byte without the start mark is popped and discarded, and no frame results.
- R13: The line bit changes only on cycles with `bit_en`=1. In cycles without it, the output and the sequence hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One pulse per line bit |
| cfg_fcs_off | input | 1 | Omit the check sequence |
| cfg_fcs_corrupt | input | 1 | Send the uncomplemented CRC |
| cfg_fill_ones | input | 1 | Fill with ones instead of flags |
| cfg_msb_first | input | 1 | Send data bit 7 first |
| cfg_invert | input | 1 | Complement the line output |
| cfg_hold_start | input | 1 | Start no new frame |
| fifo_empty | input | 1 | Byte queue is empty |
| fifo_data | input | 8 | Head byte of the queue |
| fifo_sop | input | 1 | Head byte starts a packet |
| fifo_eop | input | 1 | Head byte ends a packet |
| fifo_pop | output | 1 | Consume the head byte this cycle |
| ser_out | output | 1 | Serial line output |

## Verification
The bench builds the engine with its defaults: a 16-bit check of reflected polynomial 8408h seeded with FFFFh, and a stuffing run of five. That size puts every stuffing corner within a few packets. Bytes FFh and F8h force insertion inside a byte and across byte boundaries. A random check value can also force insertion just ahead of the closing flag. The enable is also run with gaps, so the hold behaviour between pulses and the pop timing are exercised on the same frames as the back-to-back case.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int OCTET = 8;
  localparam logic [OCTET-1:0] FLAG_BYTE = 8'h7E;

  typedef enum logic [2:0] {
    PH_FILL  = 3'd0,
    PH_OPEN  = 3'd1,
    PH_DATA  = 3'd2,
    PH_FCS   = 3'd3,
    PH_CLOSE = 3'd4,
    PH_ABORT = 3'd5
  } phase_e;
endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter int           W        = 16,
  parameter logic [W-1:0] POLY_REV = 16'h8408,
  parameter logic [W-1:0] SEED     = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         adv,
  input  logic         din,
  output logic [W-1:0] crc_nxt
);
  logic [W-1:0] crc_q, crc_d;

  always_comb begin
    crc_nxt = crc_q;
    if (adv) crc_nxt = (crc_q >> 1) ^ ((crc_q[0] ^ din) ? POLY_REV : '0);
  end

  always_comb begin
    crc_d = init ? SEED : crc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else        crc_q <= crc_d;
  end

  // R6: the register restarts from the seed at the start of every frame body
  p_crc_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc_q == SEED));

  // R6: the register only moves while data bits are being shifted or it is seeded
  p_crc_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !adv) |=> $stable(crc_q));
endmodule

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic stuffable,
  input  logic bit_val,
  output logic insert
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] run_q, run_d;

  assign insert = (run_q == CW'(RUN));

  always_comb begin
    run_d = run_q;
    if (adv) begin
      if (insert)                    run_d = '0;
      else if (stuffable && bit_val) run_d = run_q + 1'b1;
      else                           run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // R5: an inserted zero always breaks the run
  p_run_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && insert) |=> (run_q == '0));

  // R5: the run count never passes the insertion threshold
  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CW'(RUN));

  // R5: bits outside the frame body never feed the run
  p_run_body_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !insert && !stuffable) |=> (run_q == '0));
endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
  import hdlc_tx_pkg::*;
#(
  parameter int FCS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             cfg_fcs_off,
  input  logic             cfg_fcs_corrupt,
  input  logic             cfg_fill_ones,
  input  logic             cfg_msb_first,
  input  logic             cfg_hold_start,
  input  logic             fifo_empty,
  input  logic [OCTET-1:0] fifo_data,
  input  logic             fifo_sop,
  input  logic             fifo_eop,
  input  logic [FCS_W-1:0] crc_nxt,
  output logic             fifo_pop,
  output logic             cur_bit,
  output logic             cur_stuffable,
  output logic             crc_init,
  output logic             crc_adv
);
  localparam int IW = $clog2(FCS_W);
  localparam int OW = $clog2(OCTET);

  phase_e           phase_q, phase_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [OCTET-1:0] byte_q, byte_d;
  logic             last_q, last_d;
  logic [FCS_W-1:0] fcs_q, fcs_d;
  logic             unit_end;
  logic [OW-1:0]    oct_idx;

  assign oct_idx  = idx_q[OW-1:0];
  assign unit_end = (phase_q == PH_FCS) ? (idx_q == IW'(FCS_W - 1))
                                        : (idx_q == IW'(OCTET - 1));

  // bit presented to the line for the current position
  always_comb begin
    cur_stuffable = 1'b0;
    case (phase_q)
      PH_FILL:  cur_bit = cfg_fill_ones | FLAG_BYTE[oct_idx];
      PH_OPEN,
      PH_CLOSE: cur_bit = FLAG_BYTE[oct_idx];
      PH_DATA: begin
        cur_stuffable = 1'b1;
        cur_bit = cfg_msb_first ? byte_q[OW'(OCTET - 1) - oct_idx] : byte_q[oct_idx];
      end
      PH_FCS: begin
        cur_stuffable = 1'b1;
        cur_bit = fcs_q[idx_q];
      end
      default:  cur_bit = 1'b1;
    endcase
  end

  assign crc_adv  = step && (phase_q == PH_DATA);
  assign crc_init = step && (phase_q == PH_OPEN) && unit_end;

  // sequencing across units
  always_comb begin
    phase_d  = phase_q;
    idx_d    = idx_q;
    byte_d   = byte_q;
    last_d   = last_q;
    fcs_d    = fcs_q;
    fifo_pop = 1'b0;
    if (step) begin
      idx_d = idx_q + 1'b1;
      if (unit_end) begin
        idx_d = '0;
        case (phase_q)
          PH_FILL: begin
            if (!fifo_empty) begin
              if (!fifo_sop)            fifo_pop = 1'b1;
              else if (!cfg_hold_start) phase_d  = PH_OPEN;
            end
          end
          PH_OPEN, PH_DATA: begin
            if ((phase_q == PH_DATA) && last_q) begin
              phase_d = cfg_fcs_off ? PH_CLOSE : PH_FCS;
              fcs_d   = cfg_fcs_corrupt ? crc_nxt : ~crc_nxt;
            end else if (fifo_empty) begin
              phase_d = PH_ABORT;
            end else begin
              fifo_pop = 1'b1;
              byte_d   = fifo_data;
              last_d   = fifo_eop;
              phase_d  = PH_DATA;
            end
          end
          PH_FCS:  phase_d = PH_CLOSE;
          default: phase_d = PH_FILL;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
      idx_q   <= '0;
      byte_q  <= '0;
      last_q  <= 1'b0;
      fcs_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      byte_q  <= byte_d;
      last_q  <= last_d;
      fcs_q   <= fcs_d;
    end
  end

  // R3: a pop only happens on an enabled bit with a byte present
  p_pop_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (step && !fifo_empty));

  // R10: a held start keeps the engine in fill
  p_hold_keeps_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && unit_end && (phase_q == PH_FILL) && cfg_hold_start) |=> (phase_q == PH_FILL));

  // R11: an underrun inside a packet leads to the abort unit
  p_underrun_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && unit_end && (phase_q == PH_DATA) && !last_q && fifo_empty) |=> (phase_q == PH_ABORT));

  // R6: the check sequence is always closed by a flag
  p_fcs_then_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && unit_end && (phase_q == PH_FCS)) |=> (phase_q == PH_CLOSE));

  // R13: no movement between enable pulses
  p_hold_between_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(phase_q) && $stable(idx_q)));
endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
  import hdlc_tx_pkg::*;
#(
  parameter int               FCS_W    = 16,
  parameter logic [FCS_W-1:0] POLY_REV = 16'h8408,
  parameter logic [FCS_W-1:0] SEED     = 16'hFFFF,
  parameter int               RUN      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       cfg_fcs_off,
  input  logic       cfg_fcs_corrupt,
  input  logic       cfg_fill_ones,
  input  logic       cfg_msb_first,
  input  logic       cfg_invert,
  input  logic       cfg_hold_start,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  input  logic       fifo_sop,
  input  logic       fifo_eop,
  output logic       fifo_pop,
  output logic       ser_out
);
  logic             insert;
  logic             step;
  logic             cur_bit;
  logic             cur_stuffable;
  logic             crc_init;
  logic             crc_adv;
  logic [FCS_W-1:0] crc_nxt;
  logic             line_q, line_d;

  assign step = bit_en && !insert;

  hdlc_tx_seq #(.FCS_W(FCS_W)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .step            (step),
    .cfg_fcs_off     (cfg_fcs_off),
    .cfg_fcs_corrupt (cfg_fcs_corrupt),
    .cfg_fill_ones   (cfg_fill_ones),
    .cfg_msb_first   (cfg_msb_first),
    .cfg_hold_start  (cfg_hold_start),
    .fifo_empty      (fifo_empty),
    .fifo_data       (fifo_data),
    .fifo_sop        (fifo_sop),
    .fifo_eop        (fifo_eop),
    .crc_nxt         (crc_nxt),
    .fifo_pop        (fifo_pop),
    .cur_bit         (cur_bit),
    .cur_stuffable   (cur_stuffable),
    .crc_init        (crc_init),
    .crc_adv         (crc_adv)
  );

  hdlc_tx_crc #(.W(FCS_W), .POLY_REV(POLY_REV), .SEED(SEED)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (crc_init),
    .adv     (crc_adv),
    .din     (cur_bit),
    .crc_nxt (crc_nxt)
  );

  hdlc_tx_stuff #(.RUN(RUN)) u_stuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (bit_en),
    .stuffable (cur_stuffable),
    .bit_val   (cur_bit),
    .insert    (insert)
  );

  always_comb begin
    line_d = line_q;
    if (bit_en) line_d = insert ? 1'b0 : cur_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_d;
  end

  assign ser_out = line_q ^ cfg_invert;

  // R5: an insertion slot puts a zero on the line
  p_stuffed_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && insert) |=> !line_q);

  // R13: the line level holds without an enable pulse
  p_line_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_q));

  // R3: the queue is never consumed while an insertion slot is being sent
  p_no_pop_on_stuff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    insert |-> !fifo_pop);
endmodule

// File: tb/sim_hdlc_tx_engine.sv
module sim_hdlc_tx_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       bit_en;
  logic       cfg_fcs_off, cfg_fcs_corrupt, cfg_fill_ones, cfg_msb_first;
  logic       cfg_invert, cfg_hold_start;
  logic       fifo_empty, fifo_sop, fifo_eop;
  logic [7:0] fifo_data;
  logic       fifo_pop, ser_out;

  hdlc_tx_engine u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .cfg_fcs_off(cfg_fcs_off), .cfg_fcs_corrupt(cfg_fcs_corrupt),
    .cfg_fill_ones(cfg_fill_ones), .cfg_msb_first(cfg_msb_first),
    .cfg_invert(cfg_invert), .cfg_hold_start(cfg_hold_start),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_sop(fifo_sop),
    .fifo_eop(fifo_eop), .fifo_pop(fifo_pop), .ser_out(ser_out)
  );

  localparam logic [7:0] FLAG = 8'h7E;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // bench-side byte queue: {sop, eop, data}
  logic [9:0] fifo_q[$];

  // reference model state
  int         mbits[$];  // 0/1 framing bit, 2/3 body bit, 10+i fill position i
  int         mmode;     // 0 fill 1 open 2 data 3 fcs 4 close 5 abort
  int         ones;
  logic [15:0] mcrc;
  logic        mlast;
  logic        line_exp;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic head_update();
    fifo_empty = (fifo_q.size() == 0);
    if (fifo_q.size() != 0) begin
      fifo_sop  = fifo_q[0][9];
      fifo_eop  = fifo_q[0][8];
      fifo_data = fifo_q[0][7:0];
    end else begin
      fifo_sop = 1'b0; fifo_eop = 1'b0; fifo_data = 8'h00;
    end
  endtask

  task automatic push_fill();
    for (int i = 0; i < 8; i++) mbits.push_back(10 + i);
  endtask

  task automatic push_flag();
    for (int i = 0; i < 8; i++) mbits.push_back(int'(FLAG[i]));
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      logic bt;
      bt = cfg_msb_first ? b[7-k] : b[k];
      mbits.push_back(2 + int'(bt));
      mcrc = {1'b0, mcrc[15:1]} ^ ((mcrc[0] ^ bt) ? 16'h8408 : 16'h0000);
    end
  endtask

  task automatic push_fcs();
    logic [15:0] v;
    v = cfg_fcs_corrupt ? mcrc : ~mcrc;
    for (int k = 0; k < 16; k++) mbits.push_back(2 + int'(v[k]));
  endtask

  task automatic model_refill(output bit ep);
    ep = 1'b0;
    case (mmode)
      0: begin
        if (fifo_q.size() != 0 && !fifo_q[0][9]) ep = 1'b1;
        if (fifo_q.size() != 0 && fifo_q[0][9] && !cfg_hold_start) begin
          mmode = 1; push_flag();
        end else push_fill();
      end
      1, 2: begin
        if (mmode == 2 && mlast) begin
          if (cfg_fcs_off) begin mmode = 4; push_flag(); end
          else begin mmode = 3; push_fcs(); end
        end else if (fifo_q.size() == 0) begin
          mmode = 5;
          for (int i = 0; i < 8; i++) mbits.push_back(1);
        end else begin
          if (mmode == 1) mcrc = 16'hFFFF;
          ep = 1'b1; mlast = fifo_q[0][8]; mmode = 2;
          push_byte(fifo_q[0][7:0]);
        end
      end
      3: begin mmode = 4; push_flag(); end
      default: begin mmode = 0; push_fill(); end
    endcase
  endtask

  task automatic model_step(output bit eb, output bit ep);
    int c;
    ep = 1'b0;
    if (ones == 5) begin
      eb = 1'b0; ones = 0;
    end else begin
      c = mbits.pop_front();
      if (c >= 10) begin
        eb = cfg_fill_ones ? 1'b1 : FLAG[c-10]; ones = 0;
      end else if (c >= 2) begin
        eb = (c == 3); ones = eb ? ones + 1 : 0;
      end else begin
        eb = (c == 1); ones = 0;
      end
      if (mbits.size() == 0) model_refill(ep);
    end
  endtask

  // one cycle: drive at negedge, check pop before the edge, check line after it
  task automatic tick(input bit en);
    bit eb, ep;
    eb = 1'b0;
    bit_en = en;
    #1;
    if (en) model_step(eb, ep);
    else    ep = 1'b0;
    chk(fifo_pop === ep, cur_req, "pop", 32'(fifo_pop), 32'(ep));
    @(posedge clk);
    #1;
    if (ep && fifo_q.size() != 0) void'(fifo_q.pop_front());
    head_update();
    if (en) line_exp = eb;
    @(negedge clk);
    chk(ser_out === (line_exp ^ cfg_invert), cur_req, "line",
        32'(ser_out), 32'(line_exp ^ cfg_invert));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  task automatic push_pkt4(input logic [7:0] b0, b1, b2, b3);
    fifo_q.push_back({2'b10, b0});
    fifo_q.push_back({2'b00, b1});
    fifo_q.push_back({2'b00, b2});
    fifo_q.push_back({2'b01, b3});
    head_update();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0;
    cfg_fcs_off = 0; cfg_fcs_corrupt = 0; cfg_fill_ones = 0; cfg_msb_first = 0;
    cfg_invert = 0; cfg_hold_start = 0;
    head_update();
    mmode = 0; ones = 0; mcrc = 16'hFFFF; mlast = 1'b0; line_exp = 1'b1;
    push_fill();
    repeat (3) @(negedge clk);
    // R1: idle level during reset
    chk(ser_out === 1'b1, "R1", "reset level", 32'(ser_out), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ser_out === 1'b1, "R1", "level after release", 32'(ser_out), 32'd1);
    chk(fifo_pop === 1'b0, "R1", "no pop after release", 32'(fifo_pop), 32'd0);

    cur_req = "R2 flag fill";
    run(24);
    cfg_fill_ones = 1; cur_req = "R2 ones fill";
    run(16);
    cfg_fill_ones = 0;

    cur_req = "R3 R5 R6 lsb-first frame";
    push_pkt4(8'h12, 8'hFF, 8'hF8, 8'h3F);
    run(120);
    chk(fifo_q.size() == 0, "R3", "all bytes consumed", 32'(fifo_q.size()), 32'd0);

    cur_req = "R4 msb-first frame";
    cfg_msb_first = 1;
    push_pkt4(8'h1F, 8'hC0, 8'hFF, 8'h81);
    run(120);
    cfg_msb_first = 0;

    cur_req = "R7 corrupted check";
    cfg_fcs_corrupt = 1;
    push_pkt4(8'hA5, 8'h7E, 8'h00, 8'hFF);
    run(120);

    cur_req = "R7 R8 check off";
    cfg_fcs_off = 1;
    push_pkt4(8'h3E, 8'hFC, 8'h01, 8'h7F);
    run(100);
    cfg_fcs_off = 0; cfg_fcs_corrupt = 0;

    cur_req = "R9 inverted line";
    cfg_invert = 1;
    run(4);
    push_pkt4(8'hF0, 8'h0F, 8'hFF, 8'h55);
    cfg_fill_ones = 1;
    run(120);
    cfg_invert = 0; cfg_fill_ones = 0;

    cur_req = "R10 held start";
    cfg_hold_start = 1;
    push_pkt4(8'h11, 8'h22, 8'h33, 8'h44);
    run(60);
    chk(fifo_q.size() == 4, "R10", "held bytes remain", 32'(fifo_q.size()), 32'd4);
    cfg_hold_start = 0;
    run(120);
    chk(fifo_q.size() == 0, "R10", "released frame consumed", 32'(fifo_q.size()), 32'd0);

    cur_req = "R11 underrun abort";
    fifo_q.push_back({2'b10, 8'hFE});
    fifo_q.push_back({2'b00, 8'h07});
    head_update();
    run(80);

    cur_req = "R12 stray byte";
    fifo_q.push_back({2'b00, 8'h99});
    head_update();
    run(20);
    chk(fifo_q.size() == 0, "R12", "stray byte dropped", 32'(fifo_q.size()), 32'd0);

    cur_req = "R13 gapped enable";
    push_pkt4(8'hFF, 8'hFF, 8'h3C, 8'hE7);
    for (int i = 0; i < 360; i++) tick((i % 3) != 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule